// File: doc/BRIEF.md
# Triggered Single-Channel DMA Mover

This block is one DMA channel with a small register file. Software chooses which event starts a unit transfer. A four-bit cause code and a mode bit select the event. In basic mode it can be a falling edge on an external pin, or the rising edge of one of fourteen hardware trigger lines. In extended mode it can be both edges of that pin, or one of two serial-I/O trigger lines. Software can also raise a request from the select register.

A selected event latches a pending flag. When the channel is enabled and idle, the pending flag starts one transfer on a request/acknowledge bus. The block presents the source and destination addresses and the unit size, and holds the request until it is acknowledged. After each unit, every address set to forward moves by the unit size, and the remaining count drops by one. When the count runs out, single mode switches the channel off. Repeat mode reloads the addresses and the count and keeps the channel running.

Top module: `dma_chan`

## Requirements
- R1: Register map on `reg_addr`: 0 is the select register, 1 the control register, and 2, 3, 4 the source, destination and count reload values. Writing 2, 3 or 4 also loads the current copy. Addresses 5, 6 and 7 read back the current source, destination and count, and writes to them do nothing. After reset, registers 0 and 1 read 0x00 and `bus_req` is low.
- R2: Select register layout: bits 3..0 are the cause code and bit 6 is the mode (0 basic, 1 extended). Bit 7 is the software request bit and always reads 0. Bits 5..4 read 0 whatever is written.
- R3: Control register layout: bit 0 is the unit size (1 byte, 0 two bytes), bit 1 is repeat, bit 2 is pending, bit 3 is enable, bit 4 is source forward and bit 5 is destination forward. Bits 7..6 read 0.
- R4: A write to register 0 raises a request only when the written value has bit 7 = 1, bit 6 = 0 and code 0001. Any other combination raises none.
- R5: A selected event sets pending. Writing 0 to bit 2 clears it, and writing 1 leaves it as it was. If an event arrives in the same cycle as a clearing write, pending ends up set.
- R6: If a control write sets both direction bits, destination forward is stored as 0 and source forward keeps the written value.
- R7: Cause mapping. In basic mode, code 0 is a falling edge of `ext_pin`, and codes 2..15 are the rising edge of `hw_trig[code-2]`. In extended mode, code 7 is either edge of `ext_pin`, and codes 5 and 6 are the rising edge of `ser_trig[0]` and `ser_trig[1]`. Every other extended code selects nothing.
- R8: When enable and pending are set and the channel is idle, `bus_req` rises with the current addresses and `bus_byte`, and pending clears. On `bus_ack`, each forward address grows by 1 (byte unit) or 2 (two-byte unit), and the count drops by one.
- R9: In single mode, the unit that brings the count to zero clears enable.
- R10: In repeat mode, the unit that brings the count to zero reloads the addresses and the count from the reload registers, and enable stays set.
- R11: An event arriving while the channel is disabled sets pending but starts no transfer. The transfer starts once enable is set.
- R12: Trigger inputs pass through a two-flop synchroniser. One pulse, however long, yields exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | RDW | Write data |
| reg_rdata | output | RDW | Read data for `reg_addr` |
| ext_pin | input | 1 | External interrupt pin |
| hw_trig | input | NHW | Basic-mode hardware trigger lines |
| ser_trig | input | 2 | Extended-mode serial-I/O trigger lines |
| bus_req | output | 1 | Transfer request, held until acknowledged |
| bus_src | output | AW | Current source address |
| bus_dst | output | AW | Current destination address |
| bus_byte | output | 1 | 1 for a byte unit, 0 for a two-byte unit |
| bus_ack | input | 1 | Transfer acknowledge |

## Verification
Two things can touch the pending flag in the same cycle: a selected trigger edge setting it, and a software write clearing it. The bench raises a hardware trigger, then counts the synchroniser stages so that the clearing control write is sampled in exactly the cycle the edge is detected. The pending bit must read back as set. It is then checked on its own against a plain clear and a write of 1, so the priority rule is judged separately from each action alone.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    // Control fields; packing order gives bit 5 down to bit 0.
    typedef struct packed {
        logic dst_fwd;
        logic src_fwd;
        logic en;
        logic pend;
        logic rpt;
        logic byte_u;
    } ctrl_t;

    typedef struct packed {
        logic       ext;
        logic [3:0] code;
    } sel_t;

    localparam logic [3:0] CODE_PIN_FALL = 4'd0;
    localparam logic [3:0] CODE_SW       = 4'd1;
    localparam logic [3:0] CODE_HW_BASE  = 4'd2;
    localparam logic [3:0] CODE_SER0     = 4'd5;
    localparam logic [3:0] CODE_SER1     = 4'd6;
    localparam logic [3:0] CODE_PIN_BOTH = 4'd7;

endpackage

// File: rtl/dma_trig_sync.sv
module dma_trig_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] trig_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = trig_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.s2;
    assign prv = st_q.s3;

endmodule

// File: rtl/dma_cause_mux.sv
module dma_cause_mux
    import dma_chan_pkg::*;
#(
    parameter int NHW = 14
) (
    input  sel_t           sel,
    input  logic           pin_lvl,
    input  logic           pin_prv,
    input  logic [NHW-1:0] hw_lvl,
    input  logic [NHW-1:0] hw_prv,
    input  logic [1:0]     ser_lvl,
    input  logic [1:0]     ser_prv,
    output logic           hit
);

    logic [NHW-1:0] hw_rise;
    logic [1:0]     ser_rise;

    assign hw_rise  = hw_lvl & ~hw_prv;
    assign ser_rise = ser_lvl & ~ser_prv;

    always_comb begin
        hit = 1'b0;
        if (!sel.ext) begin
            if (sel.code == CODE_PIN_FALL) hit = pin_prv & ~pin_lvl;
            for (int i = 0; i < NHW; i++) begin
                if (sel.code == CODE_HW_BASE + 4'(i)) hit = hw_rise[i];
            end
        end else begin
            unique case (sel.code)
                CODE_PIN_BOTH: hit = pin_lvl ^ pin_prv;
                CODE_SER0:     hit = ser_rise[0];
                CODE_SER1:     hit = ser_rise[1];
                default:       hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int RDW   = 16,
    parameter int CODEW = 4,
    localparam int NHW  = (1 << CODEW) - 2,
    localparam int NTRG = NHW + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [2:0]     reg_addr,
    input  logic [RDW-1:0] reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    input  logic           ext_pin,
    input  logic [NHW-1:0] hw_trig,
    input  logic [1:0]     ser_trig,
    output logic           bus_req,
    output logic [AW-1:0]  bus_src,
    output logic [AW-1:0]  bus_dst,
    output logic           bus_byte,
    input  logic           bus_ack
);

    typedef struct packed {
        sel_t          sel;
        ctrl_t         ctrl;
        logic          busy;
        logic [AW-1:0] src_rl;
        logic [AW-1:0] dst_rl;
        logic [CW-1:0] cnt_rl;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
    } chan_t;

    chan_t st_d, st_q;

    logic [NTRG-1:0] t_lvl, t_prv;
    logic            hw_hit, sw_hit, set_evt, start, done;
    logic [AW-1:0]   step;
    logic [CW-1:0]   cnt_dec;

    dma_trig_sync #(.W(NTRG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in ({ser_trig, hw_trig, ext_pin}),
        .lvl     (t_lvl),
        .prv     (t_prv)
    );

    dma_cause_mux #(.NHW(NHW)) u_mux (
        .sel     (st_q.sel),
        .pin_lvl (t_lvl[0]),
        .pin_prv (t_prv[0]),
        .hw_lvl  (t_lvl[NHW:1]),
        .hw_prv  (t_prv[NHW:1]),
        .ser_lvl (t_lvl[NTRG-1:NHW+1]),
        .ser_prv (t_prv[NTRG-1:NHW+1]),
        .hit     (hw_hit)
    );

    assign sw_hit  = reg_wr && reg_addr == 3'd0 && reg_wdata[7] && !reg_wdata[6]
                     && reg_wdata[3:0] == CODE_SW;
    assign set_evt = hw_hit | sw_hit;
    assign start   = st_q.ctrl.en && st_q.ctrl.pend && !st_q.busy;
    assign done    = st_q.busy && bus_ack;
    assign step    = st_q.ctrl.byte_u ? AW'(1) : AW'(2);
    assign cnt_dec = st_q.cnt - CW'(1);

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            unique case (reg_addr)
                3'd0: begin
                    st_d.sel.ext  = reg_wdata[6];
                    st_d.sel.code = reg_wdata[3:0];
                end
                3'd1: begin
                    st_d.ctrl.byte_u  = reg_wdata[0];
                    st_d.ctrl.rpt     = reg_wdata[1];
                    st_d.ctrl.pend    = st_q.ctrl.pend & reg_wdata[2];
                    st_d.ctrl.en      = reg_wdata[3];
                    st_d.ctrl.src_fwd = reg_wdata[4];
                    st_d.ctrl.dst_fwd = reg_wdata[5] & ~reg_wdata[4];
                end
                3'd2: begin
                    st_d.src_rl = reg_wdata[AW-1:0];
                    st_d.src    = reg_wdata[AW-1:0];
                end
                3'd3: begin
                    st_d.dst_rl = reg_wdata[AW-1:0];
                    st_d.dst    = reg_wdata[AW-1:0];
                end
                3'd4: begin
                    st_d.cnt_rl = reg_wdata[CW-1:0];
                    st_d.cnt    = reg_wdata[CW-1:0];
                end
                default: ;
            endcase
        end
        if (start) begin
            st_d.busy      = 1'b1;
            st_d.ctrl.pend = 1'b0;
        end
        if (done) begin
            st_d.busy = 1'b0;
            if (st_q.ctrl.src_fwd) st_d.src = st_q.src + step;
            if (st_q.ctrl.dst_fwd) st_d.dst = st_q.dst + step;
            st_d.cnt = cnt_dec;
            if (cnt_dec == '0) begin
                if (st_q.ctrl.rpt) begin
                    st_d.src = st_q.src_rl;
                    st_d.dst = st_q.dst_rl;
                    st_d.cnt = st_q.cnt_rl;
                end else begin
                    st_d.ctrl.en = 1'b0;
                end
            end
        end
        if (set_evt) st_d.ctrl.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            3'd0:    reg_rdata = RDW'({1'b0, st_q.sel.ext, 2'b00, st_q.sel.code});
            3'd1:    reg_rdata = RDW'({2'b00, st_q.ctrl});
            3'd2:    reg_rdata = RDW'(st_q.src_rl);
            3'd3:    reg_rdata = RDW'(st_q.dst_rl);
            3'd4:    reg_rdata = RDW'(st_q.cnt_rl);
            3'd5:    reg_rdata = RDW'(st_q.src);
            3'd6:    reg_rdata = RDW'(st_q.dst);
            default: reg_rdata = RDW'(st_q.cnt);
        endcase
    end

    assign bus_req  = st_q.busy;
    assign bus_src  = st_q.src;
    assign bus_dst  = st_q.dst;
    assign bus_byte = st_q.ctrl.byte_u;

    // R6: the two forward bits are never both held
    a_r6_one_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ctrl.src_fwd && st_q.ctrl.dst_fwd));

    // R8: a start with no new event leaves pending clear
    a_r8_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !set_evt) |=> !st_q.ctrl.pend);

    // R5: a clearing write with no event leaves pending clear
    a_r5_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1 && !reg_wdata[2] && !set_evt) |=> !st_q.ctrl.pend);

    // R8: forward source address advances by the unit size
    a_r8_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.ctrl.src_fwd && st_q.cnt != CW'(1) && !reg_wr)
        |=> st_q.src == $past(st_q.src + step));

    // R9: last unit in single mode turns the channel off
    a_r9_single_off: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.ctrl.rpt && st_q.cnt == CW'(1)) |=> !st_q.ctrl.en);

    // R10: last unit in repeat mode reloads the count
    a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.ctrl.rpt && st_q.cnt == CW'(1) && !reg_wr)
        |=> (st_q.cnt == st_q.cnt_rl && st_q.ctrl.en));

    // R11: a request only rises while enabled
    a_r11_no_start_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(st_q.ctrl.en));

endmodule

// File: tb/sim_dma_chan.sv
module sim_dma_chan;

    localparam int CLK_PERIOD = 10;
    localparam int NHW = 14;
    localparam int NV  = 11;

    typedef struct packed {
        logic [7:0]  sel;
        logic [7:0]  ctrl;
        logic [2:0]  kind;
        logic [3:0]  idx;
        logic [15:0] cnt;
        logic [15:0] xs;
        logic [15:0] xd;
        logic [15:0] xc;
        logic [7:0]  xctrl;
    } vec_t;

    // kind: 1 pin low pulse, 2 hw_trig[idx], 3 ser_trig[idx], 4 select write, 5 pin and ser_trig[0]
    localparam vec_t VEC [NV] = '{
        '{8'h00, 8'h18, 3'd1, 4'd0,  16'd4, 16'h0102, 16'h0200, 16'd3, 8'h18},
        '{8'h47, 8'h29, 3'd1, 4'd0,  16'd4, 16'h0100, 16'h0202, 16'd2, 8'h29},
        '{8'h03, 8'h19, 3'd2, 4'd1,  16'd4, 16'h0101, 16'h0200, 16'd3, 8'h19},
        '{8'h03, 8'h19, 3'd2, 4'd2,  16'd4, 16'h0100, 16'h0200, 16'd4, 8'h19},
        '{8'h45, 8'h08, 3'd3, 4'd0,  16'd4, 16'h0100, 16'h0200, 16'd3, 8'h08},
        '{8'h44, 8'h08, 3'd5, 4'd0,  16'd4, 16'h0100, 16'h0200, 16'd4, 8'h08},
        '{8'h81, 8'h38, 3'd4, 4'd0,  16'd4, 16'h0102, 16'h0200, 16'd3, 8'h18},
        '{8'hC1, 8'h08, 3'd4, 4'd0,  16'd4, 16'h0100, 16'h0200, 16'd4, 8'h08},
        '{8'h82, 8'h08, 3'd4, 4'd0,  16'd4, 16'h0100, 16'h0200, 16'd4, 8'h08},
        '{8'h0F, 8'h08, 3'd2, 4'd13, 16'd4, 16'h0100, 16'h0200, 16'd3, 8'h08},
        '{8'h46, 8'h08, 3'd3, 4'd1,  16'd4, 16'h0100, 16'h0200, 16'd3, 8'h08}
    };

    function automatic string vtag(int i);
        case (i)
            6:       return "R6 R4";
            7, 8:    return "R4";
            0, 1, 2: return "R7 R8";
            default: return "R7";
        endcase
    endfunction

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [2:0]     reg_addr = 3'd0;
    logic [15:0]    reg_wdata = '0;
    logic [15:0]    reg_rdata;
    logic           ext_pin = 1'b1;
    logic [NHW-1:0] hw_trig = '0;
    logic [1:0]     ser_trig = '0;
    logic           bus_req, bus_byte, bus_ack;
    logic [15:0]    bus_src, bus_dst;
    logic           ack_en = 1'b1;
    int             checks = 0;
    int             failures = 0;
    logic           finished = 1'b0;

    assign bus_ack = bus_req & ack_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .hw_trig(hw_trig), .ser_trig(ser_trig), .bus_req(bus_req),
        .bus_src(bus_src), .bus_dst(bus_dst), .bus_byte(bus_byte), .bus_ack(bus_ack)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ext_pin = 1'b1; hw_trig = '0; ser_trig = '0; ack_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] sel, input logic [7:0] ctrl, input logic [15:0] cnt);
        wr(3'd2, 16'h0100);
        wr(3'd3, 16'h0200);
        wr(3'd4, cnt);
        wr(3'd0, {8'h00, sel & 8'h7F});
        wr(3'd1, {8'h00, ctrl});
    endtask

    task automatic pin_pulse();
        ext_pin = 1'b0;
        repeat (2) @(negedge clk);
        ext_pin = 1'b1;
    endtask

    task automatic hw_pulse(input int k, input int len);
        hw_trig[k] = 1'b1;
        repeat (len) @(negedge clk);
        hw_trig[k] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(3'd0, v); chk("R1 select reset", v, 16'h0000);
        rd(3'd1, v); chk("R1 control reset", v, 16'h0000);
        chk("R1 bus_req reset", {15'd0, bus_req}, 16'h0000);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            do_reset();
            setup(VEC[i].sel, VEC[i].ctrl, VEC[i].cnt);
            case (VEC[i].kind)
                3'd1: pin_pulse();
                3'd2: hw_pulse(int'(VEC[i].idx), 2);
                3'd3: begin
                    ser_trig[VEC[i].idx] = 1'b1;
                    repeat (2) @(negedge clk);
                    ser_trig = '0;
                end
                3'd4: wr(3'd0, {8'h00, VEC[i].sel});
                default: begin
                    ser_trig[0] = 1'b1; ext_pin = 1'b0;
                    repeat (2) @(negedge clk);
                    ser_trig = '0; ext_pin = 1'b1;
                end
            endcase
            repeat (12) @(negedge clk);
            rd(3'd5, v); chk($sformatf("%s vec%0d src", vtag(i), i), v, VEC[i].xs);
            rd(3'd6, v); chk($sformatf("%s vec%0d dst", vtag(i), i), v, VEC[i].xd);
            rd(3'd7, v); chk($sformatf("%s vec%0d cnt", vtag(i), i), v, VEC[i].xc);
            rd(3'd1, v); chk($sformatf("%s vec%0d ctrl", vtag(i), i), v, {8'h00, VEC[i].xctrl});
        end

        // R2 R3 reserved bits and write-only request bit
        do_reset();
        wr(3'd0, 16'h00FF);
        rd(3'd0, v); chk("R2 select readback", v, 16'h004F);
        wr(3'd1, 16'h00C3);
        rd(3'd1, v); chk("R3 control readback", v, 16'h0003);
        wr(3'd4, 16'd9);
        rd(3'd4, v); chk("R1 count reload readback", v, 16'd9);
        wr(3'd7, 16'd2);
        rd(3'd7, v); chk("R1 write to current count ignored", v, 16'd9);

        // R5 collision: trigger edge and clearing write in the same cycle
        do_reset();
        setup(8'h03, 8'h00, 16'd4);
        hw_trig[1] = 1'b1;
        repeat (2) @(negedge clk);
        wr(3'd1, 16'h0000);
        hw_trig[1] = 1'b0;
        rd(3'd1, v); chk("R5 event beats clearing write", v, 16'h0004);
        wr(3'd1, 16'h0004);
        rd(3'd1, v); chk("R5 write of 1 keeps pending", v, 16'h0004);
        wr(3'd1, 16'h0000);
        rd(3'd1, v); chk("R5 write of 0 clears pending", v, 16'h0000);
        wr(3'd1, 16'h0004);
        rd(3'd1, v); chk("R5 write of 1 does not set", v, 16'h0000);

        // R11 disabled channel latches request
        do_reset();
        setup(8'h00, 8'h00, 16'd4);
        pin_pulse();
        repeat (8) @(negedge clk);
        rd(3'd7, v); chk("R11 no transfer while disabled", v, 16'd4);
        rd(3'd1, v); chk("R11 pending latched", v, 16'h0004);
        wr(3'd1, 16'h000C);
        repeat (6) @(negedge clk);
        rd(3'd7, v); chk("R11 transfer after enable", v, 16'd3);
        rd(3'd1, v); chk("R11 pending consumed", v, 16'h0008);

        // R8 bus presentation with acknowledge held off
        do_reset();
        ack_en = 1'b0;
        setup(8'h01, 8'h19, 16'd4);
        wr(3'd0, 16'h0081);
        @(negedge clk);
        chk("R8 bus_req raised", {15'd0, bus_req}, 16'h0001);
        chk("R8 bus_src", bus_src, 16'h0100);
        chk("R8 bus_dst", bus_dst, 16'h0200);
        chk("R8 bus_byte", {15'd0, bus_byte}, 16'h0001);
        rd(3'd1, v); chk("R8 pending cleared at start", v, 16'h0019);
        ack_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 bus_req dropped", {15'd0, bus_req}, 16'h0000);
        rd(3'd5, v); chk("R8 byte step", v, 16'h0101);

        // R9 single mode terminal count
        do_reset();
        setup(8'h00, 8'h08, 16'd1);
        pin_pulse();
        repeat (10) @(negedge clk);
        rd(3'd7, v); chk("R9 count at zero", v, 16'd0);
        rd(3'd1, v); chk("R9 enable cleared", v, 16'h0000);

        // R10 repeat mode reload
        do_reset();
        setup(8'h00, 8'h1A, 16'd2);
        pin_pulse();
        repeat (10) @(negedge clk);
        rd(3'd5, v); chk("R10 first unit src", v, 16'h0102);
        rd(3'd7, v); chk("R10 first unit cnt", v, 16'd1);
        pin_pulse();
        repeat (10) @(negedge clk);
        rd(3'd5, v); chk("R10 src reloaded", v, 16'h0100);
        rd(3'd7, v); chk("R10 cnt reloaded", v, 16'd2);
        rd(3'd1, v); chk("R10 still enabled", v, 16'h001A);

        // R12 long pulse gives one request
        do_reset();
        setup(8'h04, 8'h08, 16'd4);
        hw_pulse(2, 9);
        repeat (10) @(negedge clk);
        rd(3'd7, v); chk("R12 one request per pulse", v, 16'd3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule